// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits on the address path between a processor and main memory. It holds two registers. The base register holds the lowest physical address of the partition that the running process owns. The limit register holds the number of logical addresses that process may use. For a user-mode request, the logical address is compared against the limit. If it is below the limit, the address is relocated at run time by adding the base, and the result goes to memory. If it is not below the limit, the request is dropped and an addressing-error trap is raised instead. This keeps a user process out of other partitions and out of operating-system code and data.

Only privileged software can load the two registers, and only while the supervisor-mode input is high. A write attempted in user mode changes nothing and is reported on a separate flag. Supervisor requests skip both the relocation and the check, so the physical address equals the logical address. The memory request or the trap appears one clock after the request is presented.

Top module: `reloc_guard`

## Requirements
- R1: After reset, mem_valid, trap_fault and cfg_denied are low, and base and limit are both zero. As a result, every user-mode request traps until the limit is loaded.
- R2: A configuration write with cfg_we high, sup_mode high and cfg_sel = 0 loads cfg_data[PA_W-1:0] into the base register. Requests presented from the next cycle on use the new value.
- R3: A configuration write with cfg_we high, sup_mode high and cfg_sel = 1 loads the low LA_W+1 bits of cfg_data (17 bits at the default width) into the limit register. Requests presented from the next cycle on use the new value.
- R4: A user-mode request (sup_mode low) with req_addr strictly below the limit produces, one cycle later, mem_valid high and trap_fault low. mem_addr then equals (base + req_addr) modulo 2^PA_W.
- R5: A user-mode request with req_addr greater than or equal to the limit produces, one cycle later, trap_fault high and mem_valid low. The trap lasts exactly one cycle for each offending request.
- R6: A supervisor-mode request produces, one cycle later, mem_valid high and mem_addr equal to req_addr zero-extended to PA_W. This holds whatever the base and limit hold.
- R7: A configuration write with sup_mode low leaves base and limit unchanged and raises cfg_denied for exactly one cycle, one cycle after the attempt.
- R8: A cycle with no request yields mem_valid and trap_fault both low on the following cycle. Every request yields exactly one of mem_valid or trap_fault on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_mode | input | 1 | High while the processor runs in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_data | input | CFG_W (20) | Value to load |
| cfg_denied | output | 1 | One-cycle flag for a write refused in user mode |
| req_valid | input | 1 | Address request present |
| req_addr | input | LA_W (16) | Logical address |
| mem_valid | output | 1 | Translated request issued to memory |
| mem_addr | output | PA_W (20) | Physical address |
| trap_fault | output | 1 | One-cycle addressing-error trap |

## Verification
User requests are applied at address zero, in the middle of the partition, at the last legal address and exactly at the limit. Together these separate a correct strict-less-than compare from an off-by-one compare or a less-or-equal compare. A base chosen close to the top of physical space, combined with the largest limit, makes the sum overflow, which shows whether the adder wraps modulo the physical width. Three further cases target the privileged paths. Supervisor requests beyond the limit tell a real bypass apart from a check applied in both modes. A refused user-mode write, followed by a translated request, shows whether the register really stayed unchanged. A limit value whose upper configuration bits are set shows whether the field is truncated correctly.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
   typedef enum logic {
      SEL_BASE  = 1'b0,
      SEL_LIMIT = 1'b1
   } cfg_sel_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
   import reloc_pkg::*;
#(
   parameter int PA_W  = 20,
   parameter int LIM_W = 17,
   parameter int CFG_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sup_mode,
   input  logic             cfg_we,
   input  cfg_sel_e         cfg_sel,
   input  logic [CFG_W-1:0] cfg_data,
   output logic [PA_W-1:0]  base_q,
   output logic [LIM_W-1:0] limit_q,
   output logic             denied_q
);
   generate
      if (CFG_W < PA_W || CFG_W < LIM_W) begin : g_bad_cfg_w
         $error("reloc_regs: CFG_W must cover both PA_W and LIM_W");
      end
   endgenerate

   logic grant;
   logic hit_base;
   logic hit_limit;

   assign grant     = cfg_we & sup_mode;
   assign hit_base  = grant & (cfg_sel == SEL_BASE);
   assign hit_limit = grant & (cfg_sel == SEL_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         limit_q  <= '0;
         denied_q <= 1'b0;
      end else begin
         denied_q <= cfg_we & ~sup_mode;
         if (hit_base)  base_q  <= cfg_data[PA_W-1:0];
         if (hit_limit) limit_q <= cfg_data[LIM_W-1:0];
      end
   end
endmodule

// File: rtl/reloc_bound.sv
module reloc_bound #(
   parameter int LA_W = 16,
   localparam int LIM_W = LA_W + 1
) (
   input  logic [LA_W-1:0]  addr,
   input  logic [LIM_W-1:0] limit,
   output logic             in_range
);
   logic [LIM_W-1:0] addr_w;

   assign addr_w   = {1'b0, addr};
   assign in_range = (addr_w < limit);
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
   parameter int LA_W = 16,
   parameter int PA_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            sup_mode,
   input  logic [LA_W-1:0] req_addr,
   input  logic [PA_W-1:0] base,
   input  logic            in_range,
   output logic            mem_valid,
   output logic [PA_W-1:0] mem_addr,
   output logic            trap_fault
);
   logic [PA_W-1:0] addr_ext;
   logic [PA_W-1:0] reloc_sum;

   generate
      if (PA_W > LA_W) begin : g_widen
         assign addr_ext = {{(PA_W-LA_W){1'b0}}, req_addr};
      end else begin : g_same
         assign addr_ext = req_addr;
      end
   endgenerate

   assign reloc_sum = base + addr_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_valid  <= 1'b0;
         mem_addr   <= '0;
         trap_fault <= 1'b0;
      end else begin
         mem_valid  <= 1'b0;
         trap_fault <= 1'b0;
         if (req_valid) begin
            if (sup_mode) begin
               mem_valid <= 1'b1;
               mem_addr  <= addr_ext;
            end else if (in_range) begin
               mem_valid <= 1'b1;
               mem_addr  <= reloc_sum;
            end else begin
               trap_fault <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
   import reloc_pkg::*;
#(
   parameter int LA_W = 16,
   parameter int PA_W = 20,
   localparam int LIM_W = LA_W + 1,
   localparam int CFG_W = max_int(PA_W, LIM_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sup_mode,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [CFG_W-1:0] cfg_data,
   output logic             cfg_denied,
   input  logic             req_valid,
   input  logic [LA_W-1:0]  req_addr,
   output logic             mem_valid,
   output logic [PA_W-1:0]  mem_addr,
   output logic             trap_fault
);
   generate
      if (LA_W < 2) begin : g_bad_la
         $error("reloc_guard: LA_W must be at least 2");
      end
      if (PA_W < LA_W) begin : g_bad_pa
         $error("reloc_guard: PA_W must not be narrower than LA_W");
      end
   endgenerate

   logic [PA_W-1:0]  base_q;
   logic [LIM_W-1:0] limit_q;
   logic             in_range;

   reloc_regs #(.PA_W(PA_W), .LIM_W(LIM_W), .CFG_W(CFG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sup_mode (sup_mode),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel_e'(cfg_sel)),
      .cfg_data (cfg_data),
      .base_q   (base_q),
      .limit_q  (limit_q),
      .denied_q (cfg_denied)
   );

   reloc_bound #(.LA_W(LA_W)) u_bound (
      .addr     (req_addr),
      .limit    (limit_q),
      .in_range (in_range)
   );

   reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .sup_mode   (sup_mode),
      .req_addr   (req_addr),
      .base       (base_q),
      .in_range   (in_range),
      .mem_valid  (mem_valid),
      .mem_addr   (mem_addr),
      .trap_fault (trap_fault)
   );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
   parameter int LA_W = 16,
   parameter int PA_W = 20,
   localparam int LIM_W = LA_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sup_mode,
   input logic             cfg_we,
   input logic             cfg_denied,
   input logic             req_valid,
   input logic [LA_W-1:0]  req_addr,
   input logic             mem_valid,
   input logic [PA_W-1:0]  mem_addr,
   input logic             trap_fault,
   input logic [PA_W-1:0]  base_q,
   input logic [LIM_W-1:0] limit_q
);
   logic armed;
   logic [PA_W-1:0] ext_addr;

   assign ext_addr = PA_W'(req_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R8
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid) |-> (mem_valid ^ trap_fault));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(req_valid) |-> (!mem_valid && !trap_fault));

   // R4
   legal_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && !sup_mode && ({1'b0, req_addr} < limit_q))
      |-> (mem_valid && mem_addr == $past(base_q + ext_addr)));

   // R5
   over_limit_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && !sup_mode && ({1'b0, req_addr} >= limit_q))
      |-> (trap_fault && !mem_valid));

   // R6
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && sup_mode) |-> (mem_valid && mem_addr == $past(ext_addr)));

   // R7
   locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(cfg_we && !sup_mode) |-> ($stable(base_q) && $stable(limit_q) && cfg_denied));

   // R7
   denied_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      cfg_denied |-> $past(cfg_we && !sup_mode));
endmodule

bind reloc_guard reloc_guard_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sup_mode   (sup_mode),
   .cfg_we     (cfg_we),
   .cfg_denied (cfg_denied),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .mem_valid  (mem_valid),
   .mem_addr   (mem_addr),
   .trap_fault (trap_fault),
   .base_q     (base_q),
   .limit_q    (limit_q)
);

// File: tb/sim_reloc_guard.sv
`timescale 1ns/1ps
module sim_reloc_guard;
   localparam int LA_W = 16;
   localparam int PA_W = 20;
   localparam int CFG_W = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sup_mode = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_sel = 1'b0;
   logic [CFG_W-1:0] cfg_data = '0;
   logic             cfg_denied;
   logic             req_valid = 1'b0;
   logic [LA_W-1:0]  req_addr = '0;
   logic             mem_valid;
   logic [PA_W-1:0]  mem_addr;
   logic             trap_fault;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   reloc_guard #(.LA_W(LA_W), .PA_W(PA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_denied(cfg_denied),
      .req_valid(req_valid), .req_addr(req_addr), .mem_valid(mem_valid),
      .mem_addr(mem_addr), .trap_fault(trap_fault)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Presents a request at a falling edge; outputs are checked one cycle later.
   task automatic req_chk(input string tag, input logic sup, input logic [LA_W-1:0] a,
                          input logic exp_ok, input logic [PA_W-1:0] exp_addr);
      sup_mode = sup; req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; sup_mode = 1'b0;
      chk({tag, " mem_valid"}, 32'(mem_valid), 32'(exp_ok));
      chk({tag, " trap_fault"}, 32'(trap_fault), 32'(!exp_ok));
      if (exp_ok) chk({tag, " mem_addr"}, 32'(mem_addr), 32'(exp_addr));
   endtask

   task automatic cfg_wr(input string tag, input logic sup, input logic sel,
                         input logic [CFG_W-1:0] d);
      sup_mode = sup; cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0; sup_mode = 1'b0;
      chk({tag, " cfg_denied"}, 32'(cfg_denied), 32'(!sup));
   endtask

   task automatic t_reset;
      chk("R1 reset mem_valid", 32'(mem_valid), 0);
      chk("R1 reset trap_fault", 32'(trap_fault), 0);
      chk("R1 reset cfg_denied", 32'(cfg_denied), 0);
      req_chk("R1 zero limit traps", 1'b0, 16'h0000, 1'b0, '0);
      @(negedge clk);
      chk("R5 trap lasts one cycle", 32'(trap_fault), 0);
   endtask

   task automatic t_bypass;
      req_chk("R6 bypass past limit", 1'b1, 16'hFFFF, 1'b1, 20'h0FFFF);
      req_chk("R6 bypass low", 1'b1, 16'h0123, 1'b1, 20'h00123);
   endtask

   task automatic t_translate;
      cfg_wr("R2 load base", 1'b1, 1'b0, 20'h12340);
      cfg_wr("R3 load limit", 1'b1, 1'b1, 20'h00100);
      req_chk("R4 addr zero", 1'b0, 16'h0000, 1'b1, 20'h12340);
      req_chk("R4 mid addr", 1'b0, 16'h0055, 1'b1, 20'h12395);
      req_chk("R4 last legal", 1'b0, 16'h00FF, 1'b1, 20'h1243F);
      req_chk("R5 equal to limit", 1'b0, 16'h0100, 1'b0, '0);
      req_chk("R5 far beyond", 1'b0, 16'hFFFF, 1'b0, '0);
      req_chk("R6 bypass ignores base", 1'b1, 16'h0200, 1'b1, 20'h00200);
   endtask

   task automatic t_idle;
      @(negedge clk);
      chk("R8 idle mem_valid", 32'(mem_valid), 0);
      chk("R8 idle trap_fault", 32'(trap_fault), 0);
   endtask

   task automatic t_denied;
      cfg_wr("R7 user base write", 1'b0, 1'b0, 20'h00000);
      @(negedge clk);
      chk("R7 denied one cycle", 32'(cfg_denied), 0);
      req_chk("R7 base kept", 1'b0, 16'h0010, 1'b1, 20'h12350);
      cfg_wr("R7 user limit write", 1'b0, 1'b1, 20'h0FFFF);
      req_chk("R7 limit kept", 1'b0, 16'h0100, 1'b0, '0);
   endtask

   task automatic t_limit_change;
      cfg_wr("R3 shrink limit", 1'b1, 1'b1, 20'h00020);
      req_chk("R3 below new limit", 1'b0, 16'h001F, 1'b1, 20'h1235F);
      req_chk("R3 at new limit", 1'b0, 16'h0020, 1'b0, '0);
      cfg_wr("R3 truncated limit", 1'b1, 1'b1, 20'hE0005);
      req_chk("R3 truncation legal", 1'b0, 16'h0004, 1'b1, 20'h12344);
      req_chk("R3 truncation trap", 1'b0, 16'h0005, 1'b0, '0);
   endtask

   task automatic t_wrap;
      cfg_wr("R2 high base", 1'b1, 1'b0, 20'hFFFF0);
      cfg_wr("R3 full limit", 1'b1, 1'b1, 20'h10000);
      req_chk("R4 wrap sum", 1'b0, 16'h0020, 1'b1, 20'h00010);
      req_chk("R4 top addr legal", 1'b0, 16'hFFFF, 1'b1, 20'h0FFEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_translate();
      t_idle();
      t_denied();
      t_limit_change();
      t_wrap();
      t_idle();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule